// File: doc/BRIEF.md
# Queue Channel Register Bank and Control FSM

This block holds the software-facing registers and the control state machine for each channel of a queue-based memory-to-memory copy engine. Software programs a submission ring and a completion ring for each channel: a 64-bit base address, a depth and a pointer for each ring. It then rings the doorbell by advancing the submission tail, and it drives the channel through enable, pause and queue-reset controls. A descriptor engine next to the block takes the ring pointers and a go signal. It returns its consumed head, a busy flag, an error strobe and interrupt events.

Registers are reached over a simple 32-bit bus with a one-cycle registered read. Each channel owns a 256-byte window, and channel N starts at N×0x100. Inside the window, offsets are 0x00/0x04 submission base low/high, 0x08 submission depth, 0x0C submission tail, 0x10/0x14 completion base low/high, 0x18 completion depth, 0x1C completion head, 0x20 control, 0x24 queue reset, 0x30 state, 0x40 interrupt status and 0x44 interrupt mask.

The state machine has eight named states with fixed codes:
- IDLE (0)
- RUN (1)
- DONE (2)
- PAUSED (3)
- HALT (4)
- ABORT (5)
- WAIT (6)
- BUFCLR (7)

Its transitions are:
- Queue reset: from any state to BUFCLR.
- Start: IDLE to RUN.
- Drain: RUN to DONE, then DONE to IDLE.
- Hold: IDLE or RUN to PAUSED, and Release: PAUSED to IDLE.
- Stop: RUN or PAUSED to ABORT (engine busy) or to HALT (engine quiet).
- Settle: ABORT to HALT.
- Fault: RUN to WAIT.
- Clear: WAIT to HALT.
- Rearm: HALT to IDLE.
- Restart: BUFCLR to IDLE.

Top module: `qchan_bank`

## Requirements
- R1: A write to a channel's base-low/high or depth offset at N×0x100 plus offset reads back one cycle after the read strobe. The value also appears on that channel's ring outputs. Depth fields hold entries minus one in PTR_W bits, and upper bits read 0.
- R2: Unmapped offsets, and channel windows at or above NUM_CH, read 0. Writes to them change nothing.
- R3: Control register 0x20 holds enable in bit 0 and pause in bit 4. All other bits read 0.
- R4: A write to the submission tail (0x0C) or completion head (0x1C) whose value exceeds that ring's depth register is dropped, and the old pointer is kept.
- R5: State 0x30 bits 3:0 report the state code. IDLE moves to RUN (code 1) when the queue is enabled, not paused, and the tail differs from the engine head. ring_go is high exactly in RUN.
- R6: RUN moves to DONE (code 2) when the engine head equals the tail and the engine is not busy. DONE moves to IDLE on the next cycle.
- R7: With the queue enabled, setting pause moves IDLE or RUN to PAUSED (code 3). Clearing pause returns to IDLE.
- R8: Disabling from RUN or PAUSED goes to ABORT (code 5) if the engine is busy, otherwise to HALT (code 4). ABORT leaves for HALT when busy drops, or after DRAIN_LIMIT cycles at most. HALT moves to IDLE once enabled.
- R9: An engine error in RUN moves to WAIT (code 6). WAIT holds until the queue is disabled (to HALT) or reset.
- R10: Writing 1 to bit 0 of 0x24 zeros the submission tail and completion head and enters BUFCLR (code 7) for one cycle, with ring_flush high. The reset bit reads 1 in that cycle and 0 afterwards. The state then moves to IDLE.
- R11: Interrupt status (0x40, bits 12:0) sets from engine events and clears by writing 1. A set and a clear in the same cycle leave the bit set.
- R12: irq is the OR of status bits whose mask bit (0x44, bits 12:0) is 0. A mask bit of 1 blocks that source.
- R13: After reset every register reads 0, the state is IDLE, and irq, ring_go and ring_flush are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address: channel above bit 8, offset in bits 7:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the edge that samples bus_re |
| eng_busy | input | NUM_CH | Engine has a descriptor in flight, per channel |
| eng_err | input | NUM_CH | Engine error strobe, per channel |
| eng_sq_head | input | NUM_CH*PTR_W | Engine consumed submission head, per channel |
| eng_evt | input | NUM_CH*INT_W | Interrupt source events, per channel |
| ring_go | output | NUM_CH | Channel is in RUN |
| ring_flush | output | NUM_CH | Channel is in BUFCLR; engine zeroes its head |
| sq_base | output | NUM_CH*64 | Submission ring base |
| cq_base | output | NUM_CH*64 | Completion ring base |
| sq_depth | output | NUM_CH*PTR_W | Submission depth (entries minus one) |
| cq_depth | output | NUM_CH*PTR_W | Completion depth (entries minus one) |
| sq_tail | output | NUM_CH*PTR_W | Submission tail doorbell |
| cq_head | output | NUM_CH*PTR_W | Completion head |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
A register write takes effect at the edge that samples it. A read returns the pre-edge value at the following half cycle. A state change caused by a register write therefore shows up one edge later than the write, and the bench idles one cycle before reading the state. BUFCLR lasts one cycle, so ring_flush and the zeroed pointers are checked on the ports at the half cycle after the reset write. The reset bit is read in the very next cycle to catch its single set cycle. Engine inputs are driven at a falling edge and act at the next rising edge. Each check is placed on that count of edges.

// File: rtl/qchan_pkg.sv
package qchan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_RUN    = 4'd1,
        ST_DONE   = 4'd2,
        ST_PAUSED = 4'd3,
        ST_HALT   = 4'd4,
        ST_ABORT  = 4'd5,
        ST_WAIT   = 4'd6,
        ST_BUFCLR = 4'd7
    } qstate_e;

    localparam logic [7:0] OFF_SQ_LO   = 8'h00;
    localparam logic [7:0] OFF_SQ_HI   = 8'h04;
    localparam logic [7:0] OFF_SQ_DEP  = 8'h08;
    localparam logic [7:0] OFF_SQ_TAIL = 8'h0C;
    localparam logic [7:0] OFF_CQ_LO   = 8'h10;
    localparam logic [7:0] OFF_CQ_HI   = 8'h14;
    localparam logic [7:0] OFF_CQ_DEP  = 8'h18;
    localparam logic [7:0] OFF_CQ_HEAD = 8'h1C;
    localparam logic [7:0] OFF_CTRL    = 8'h20;
    localparam logic [7:0] OFF_QRST    = 8'h24;
    localparam logic [7:0] OFF_STATE   = 8'h30;
    localparam logic [7:0] OFF_ISTS    = 8'h44 - 8'h04;
    localparam logic [7:0] OFF_IMSK    = 8'h44;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_PAUSE_BIT = 4;
    localparam int QRST_BIT       = 0;

endpackage

// File: rtl/qchan_fsm.sv
module qchan_fsm
    import qchan_pkg::*;
#(
    parameter int PTR_W       = 10,
    parameter int DRAIN_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_en,
    input  logic             q_pause,
    input  logic             rst_req,
    input  logic [PTR_W-1:0] sq_tail,
    input  logic [PTR_W-1:0] eng_head,
    input  logic             eng_busy,
    input  logic             eng_err,
    output qstate_e          state,
    output logic             ring_go,
    output logic             ring_flush
);

    localparam int CNT_W = $clog2(DRAIN_LIMIT + 1);

    qstate_e           state_q, state_d;
    logic [CNT_W-1:0]  drain_cnt;
    logic              have_work;
    logic              drain_out;

    assign have_work = (sq_tail != eng_head);
    assign drain_out = (drain_cnt == CNT_W'(DRAIN_LIMIT - 1));

    always_comb begin
        state_d = state_q;
        if (rst_req) begin
            state_d = ST_BUFCLR;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (q_en && q_pause)      state_d = ST_PAUSED;
                    else if (q_en && have_work) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (eng_err)              state_d = ST_WAIT;
                    else if (!q_en)           state_d = eng_busy ? ST_ABORT : ST_HALT;
                    else if (q_pause)         state_d = ST_PAUSED;
                    else if (!have_work && !eng_busy) state_d = ST_DONE;
                end
                ST_DONE:   state_d = ST_IDLE;
                ST_PAUSED: begin
                    if (!q_en)                state_d = eng_busy ? ST_ABORT : ST_HALT;
                    else if (!q_pause)        state_d = ST_IDLE;
                end
                ST_ABORT: begin
                    if (!eng_busy || drain_out) state_d = ST_HALT;
                end
                ST_HALT: begin
                    if (q_en)                 state_d = ST_IDLE;
                end
                ST_WAIT: begin
                    if (!q_en)                state_d = ST_HALT;
                end
                ST_BUFCLR: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            drain_cnt <= '0;
        end else begin
            state_q   <= state_d;
            drain_cnt <= (state_q == ST_ABORT) ? drain_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        state      = state_q;
        ring_go    = (state_q == ST_RUN);
        ring_flush = (state_q == ST_BUFCLR);
    end

    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |->
            $past(q_en && !q_pause && have_work)); // R5

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !rst_req) |=> state_q == ST_IDLE); // R6

    AST_ABORT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT) |-> drain_cnt < CNT_W'(DRAIN_LIMIT)); // R8

    AST_BUFCLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUFCLR && !rst_req) |=> state_q != ST_BUFCLR); // R10

endmodule

// File: rtl/qchan_regs.sv
module qchan_regs
    import qchan_pkg::*;
#(
    parameter int PTR_W = 10,
    parameter int INT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       off,
    input  logic [31:0]      wdata,
    input  logic [INT_W-1:0] eng_evt,
    input  qstate_e          state,
    input  logic             ring_flush,
    output logic [31:0]      rd_word,
    output logic [63:0]      sq_base,
    output logic [63:0]      cq_base,
    output logic [PTR_W-1:0] sq_depth,
    output logic [PTR_W-1:0] cq_depth,
    output logic [PTR_W-1:0] sq_tail,
    output logic [PTR_W-1:0] cq_head,
    output logic             q_en,
    output logic             q_pause,
    output logic             rst_req,
    output logic             irq
);

    localparam int PAD_P = 32 - PTR_W;
    localparam int PAD_I = 32 - INT_W;

    logic             rst_bit;
    logic [INT_W-1:0] int_sts, int_msk, w1c;
    logic             tail_ok, head_ok;

    assign rst_req = wr_en && (off == OFF_QRST) && wdata[QRST_BIT];
    assign tail_ok = (wdata <= {{PAD_P{1'b0}}, sq_depth});
    assign head_ok = (wdata <= {{PAD_P{1'b0}}, cq_depth});
    assign w1c     = (wr_en && off == OFF_ISTS) ? wdata[INT_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_base  <= '0;
            cq_base  <= '0;
            sq_depth <= '0;
            cq_depth <= '0;
            sq_tail  <= '0;
            cq_head  <= '0;
            q_en     <= 1'b0;
            q_pause  <= 1'b0;
            rst_bit  <= 1'b0;
            int_msk  <= '0;
        end else begin
            rst_bit <= rst_req;
            if (rst_req) begin
                sq_tail <= '0;
                cq_head <= '0;
            end else if (wr_en) begin
                case (off)
                    OFF_SQ_LO:   sq_base[31:0]  <= wdata;
                    OFF_SQ_HI:   sq_base[63:32] <= wdata;
                    OFF_SQ_DEP:  sq_depth       <= wdata[PTR_W-1:0];
                    OFF_SQ_TAIL: if (tail_ok) sq_tail <= wdata[PTR_W-1:0];
                    OFF_CQ_LO:   cq_base[31:0]  <= wdata;
                    OFF_CQ_HI:   cq_base[63:32] <= wdata;
                    OFF_CQ_DEP:  cq_depth       <= wdata[PTR_W-1:0];
                    OFF_CQ_HEAD: if (head_ok) cq_head <= wdata[PTR_W-1:0];
                    OFF_CTRL: begin
                        q_en    <= wdata[CTRL_EN_BIT];
                        q_pause <= wdata[CTRL_PAUSE_BIT];
                    end
                    OFF_IMSK:    int_msk <= wdata[INT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_sts <= '0;
        else        int_sts <= (int_sts & ~w1c) | eng_evt;
    end

    always_comb begin
        irq = |(int_sts & ~int_msk);
    end

    always_comb begin
        unique case (off)
            OFF_SQ_LO:   rd_word = sq_base[31:0];
            OFF_SQ_HI:   rd_word = sq_base[63:32];
            OFF_SQ_DEP:  rd_word = {{PAD_P{1'b0}}, sq_depth};
            OFF_SQ_TAIL: rd_word = {{PAD_P{1'b0}}, sq_tail};
            OFF_CQ_LO:   rd_word = cq_base[31:0];
            OFF_CQ_HI:   rd_word = cq_base[63:32];
            OFF_CQ_DEP:  rd_word = {{PAD_P{1'b0}}, cq_depth};
            OFF_CQ_HEAD: rd_word = {{PAD_P{1'b0}}, cq_head};
            OFF_CTRL:    rd_word = 32'(q_en) | (32'(q_pause) << CTRL_PAUSE_BIT);
            OFF_QRST:    rd_word = 32'(rst_bit) << QRST_BIT;
            OFF_STATE:   rd_word = {28'd0, state};
            OFF_ISTS:    rd_word = {{PAD_I{1'b0}}, int_sts};
            OFF_IMSK:    rd_word = {{PAD_I{1'b0}}, int_msk};
            default:     rd_word = 32'd0;
        endcase
    end

    AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_SQ_TAIL && !tail_ok) |=> $stable(sq_tail)); // R4

    AST_FLUSH_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        ring_flush |-> (sq_tail == '0 && cq_head == '0)); // R10

    AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_ISTS && eng_evt == '0) |=>
            (int_sts & $past(wdata[INT_W-1:0])) == '0); // R11

endmodule

// File: rtl/qchan_rdmux.sv
module qchan_rdmux #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [CH_W-1:0]      ch_sel,
    input  logic [NUM_CH*32-1:0] words,
    output logic [31:0]          rdata
);

    logic [31:0] pick;

    always_comb begin
        pick = 32'd0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel == CH_W'(c)) pick = words[c*32 +: 32];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= 32'd0;
        else if (rd_en) rdata <= pick;
    end

    AST_NO_CHAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ch_sel >= CH_W'(NUM_CH)) |=> rdata == 32'd0); // R2

endmodule

// File: rtl/qchan_bank.sv
module qchan_bank
    import qchan_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int PTR_W       = 10,
    parameter int INT_W       = 13,
    parameter int DRAIN_LIMIT = 64,
    parameter int ADDR_W      = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic                      bus_re,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_CH-1:0]         eng_busy,
    input  logic [NUM_CH-1:0]         eng_err,
    input  logic [NUM_CH*PTR_W-1:0]   eng_sq_head,
    input  logic [NUM_CH*INT_W-1:0]   eng_evt,
    output logic [NUM_CH-1:0]         ring_go,
    output logic [NUM_CH-1:0]         ring_flush,
    output logic [NUM_CH*64-1:0]      sq_base,
    output logic [NUM_CH*64-1:0]      cq_base,
    output logic [NUM_CH*PTR_W-1:0]   sq_depth,
    output logic [NUM_CH*PTR_W-1:0]   cq_depth,
    output logic [NUM_CH*PTR_W-1:0]   sq_tail,
    output logic [NUM_CH*PTR_W-1:0]   cq_head,
    output logic [NUM_CH-1:0]         irq
);

    localparam int CH_W = ADDR_W - 8;

    logic [CH_W-1:0]      ch_sel;
    logic [7:0]           off;
    logic [NUM_CH*32-1:0] words;

    assign ch_sel = bus_addr[ADDR_W-1:8];
    assign off    = bus_addr[7:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic    wr_en, q_en, q_pause, rst_req;
        qstate_e state;

        assign wr_en = bus_we && (ch_sel == CH_W'(c));

        qchan_regs #(.PTR_W(PTR_W), .INT_W(INT_W)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en),
            .off        (off),
            .wdata      (bus_wdata),
            .eng_evt    (eng_evt[c*INT_W +: INT_W]),
            .state      (state),
            .ring_flush (ring_flush[c]),
            .rd_word    (words[c*32 +: 32]),
            .sq_base    (sq_base[c*64 +: 64]),
            .cq_base    (cq_base[c*64 +: 64]),
            .sq_depth   (sq_depth[c*PTR_W +: PTR_W]),
            .cq_depth   (cq_depth[c*PTR_W +: PTR_W]),
            .sq_tail    (sq_tail[c*PTR_W +: PTR_W]),
            .cq_head    (cq_head[c*PTR_W +: PTR_W]),
            .q_en       (q_en),
            .q_pause    (q_pause),
            .rst_req    (rst_req),
            .irq        (irq[c])
        );

        qchan_fsm #(.PTR_W(PTR_W), .DRAIN_LIMIT(DRAIN_LIMIT)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .q_en       (q_en),
            .q_pause    (q_pause),
            .rst_req    (rst_req),
            .sq_tail    (sq_tail[c*PTR_W +: PTR_W]),
            .eng_head   (eng_sq_head[c*PTR_W +: PTR_W]),
            .eng_busy   (eng_busy[c]),
            .eng_err    (eng_err[c]),
            .state      (state),
            .ring_go    (ring_go[c]),
            .ring_flush (ring_flush[c])
        );
    end

    qchan_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rdmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (bus_re),
        .ch_sel (ch_sel),
        .words  (words),
        .rdata  (bus_rdata)
    );

endmodule

// File: tb/qchan_bank_test.sv
module qchan_bank_test;

    localparam int NUM_CH = 2;
    localparam int PTR_W  = 10;
    localparam int INT_W  = 13;
    localparam int DRAIN  = 64;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    bus_we = 1'b0, bus_re = 1'b0;
    logic [11:0]             bus_addr = '0;
    logic [31:0]             bus_wdata = '0;
    logic [31:0]             bus_rdata;
    logic [NUM_CH-1:0]       eng_busy = '0, eng_err = '0;
    logic [NUM_CH*PTR_W-1:0] eng_sq_head = '0;
    logic [NUM_CH*INT_W-1:0] eng_evt = '0;
    logic [NUM_CH-1:0]       ring_go, ring_flush, irq;
    logic [NUM_CH*64-1:0]    sq_base, cq_base;
    logic [NUM_CH*PTR_W-1:0] sq_depth, cq_depth, sq_tail, cq_head;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    qchan_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_err(eng_err), .eng_sq_head(eng_sq_head),
        .eng_evt(eng_evt), .ring_go(ring_go), .ring_flush(ring_flush),
        .sq_base(sq_base), .cq_base(cq_base), .sq_depth(sq_depth),
        .cq_depth(cq_depth), .sq_tail(sq_tail), .cq_head(cq_head), .irq(irq)
    );

    // {addr, write data, expected readback}
    localparam int NV = 15;
    localparam logic [75:0] VEC [NV] = '{
        {12'h000, 32'h1234_5678, 32'h1234_5678},   // R1
        {12'h004, 32'hCAFE_0001, 32'hCAFE_0001},   // R1
        {12'h008, 32'h0000_0007, 32'h0000_0007},   // R1
        {12'h018, 32'h0000_000F, 32'h0000_000F},   // R1
        {12'h110, 32'hA5A5_0000, 32'hA5A5_0000},   // R1
        {12'h114, 32'h0000_00FF, 32'h0000_00FF},   // R1
        {12'h108, 32'hFFFF_FFFF, 32'h0000_03FF},   // R1
        {12'h050, 32'h0000_FFFF, 32'h0000_0000},   // R2
        {12'h200, 32'h0000_DEAD, 32'h0000_0000},   // R2
        {12'h044, 32'hFFFF_FFFF, 32'h0000_1FFF},   // R12
        {12'h044, 32'h0000_0000, 32'h0000_0000},   // R12
        {12'h00C, 32'h0000_0003, 32'h0000_0003},   // R4
        {12'h00C, 32'h0000_0009, 32'h0000_0003},   // R4
        {12'h01C, 32'h0000_000F, 32'h0000_000F},   // R4
        {12'h01C, 32'h0000_0010, 32'h0000_000F}    // R4
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R13 reset state
        rd(12'h030, v); chk("R13 state", v, 0);
        rd(12'h020, v); chk("R13 ctrl", v, 0);
        chk("R13 outs", {irq, ring_go, ring_flush}, 0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][75:64], VEC[i][63:32]);
            rd(VEC[i][75:64], v);
            chk($sformatf("R1/R2/R4/R12 vec%0d", i), v, VEC[i][31:0]);
        end
        chk("R1 sq_base port", sq_base[63:0], 64'hCAFE_0001_1234_5678);
        chk("R1 depth port", sq_depth[9:0], 7);
        rd(12'h130, v); chk("R2 ch1 untouched state", v, 0);

        // R5 start: tail 3, head 0
        wr(12'h020, 32'hFFFF_FF01);
        idle(1);
        chk("R5 ring_go", ring_go[0], 1);
        rd(12'h030, v); chk("R5 run code", v, 1);
        rd(12'h020, v); chk("R3 ctrl readback", v, 1);

        // R7 pause
        wr(12'h020, 32'h11);
        idle(1);
        chk("R7 go low", ring_go[0], 0);
        rd(12'h030, v); chk("R7 paused code", v, 3);
        rd(12'h020, v); chk("R3 pause bit", v, 32'h11);
        wr(12'h020, 32'h1);
        idle(2);
        chk("R7 resumed run", ring_go[0], 1);

        // R6 drain
        eng_sq_head[9:0] = 10'd3;
        @(negedge clk);
        rd(12'h030, v); chk("R6 done code", v, 2);
        rd(12'h030, v); chk("R6 back to idle", v, 0);

        // R8 abort while busy
        eng_busy[0] = 1'b1;
        wr(12'h00C, 32'd5);
        idle(1);
        chk("R8 run again", ring_go[0], 1);
        wr(12'h020, 32'h0);
        idle(1);
        rd(12'h030, v); chk("R8 abort code", v, 5);
        eng_busy[0] = 1'b0;
        @(negedge clk);
        rd(12'h030, v); chk("R8 halt code", v, 4);

        // R8 bounded drain with busy stuck
        eng_busy[0] = 1'b1;
        wr(12'h020, 32'h1);
        idle(2);
        chk("R8 rearm run", ring_go[0], 1);
        wr(12'h020, 32'h0);
        idle(DRAIN + 8);
        rd(12'h030, v); chk("R8 drain limit halt", v, 4);
        eng_busy[0] = 1'b0;
        wr(12'h020, 32'h1);
        idle(2);
        chk("R8 halt to run", ring_go[0], 1);

        // R9 error
        eng_err[0] = 1'b1;
        @(negedge clk);
        eng_err[0] = 1'b0;
        rd(12'h030, v); chk("R9 wait code", v, 6);
        chk("R9 go low", ring_go[0], 0);
        idle(3);
        rd(12'h030, v); chk("R9 wait holds", v, 6);

        // R10 queue reset
        eng_sq_head[9:0] = 10'd0;
        wr(12'h024, 32'h1);
        chk("R10 flush high", ring_flush[0], 1);
        chk("R10 ptrs zero", {sq_tail[9:0], cq_head[9:0]}, 0);
        rd(12'h024, v); chk("R10 bit set one cycle", v, 1);
        chk("R10 flush low", ring_flush[0], 0);
        rd(12'h024, v); chk("R10 bit self-clears", v, 0);
        rd(12'h030, v); chk("R10 idle after", v, 0);

        // R11 / R12 on channel 1
        eng_evt[25:13] = 13'h0005;
        @(negedge clk);
        eng_evt = '0;
        rd(12'h140, v); chk("R11 status set", v, 5);
        chk("R12 irq up", irq[1], 1);
        wr(12'h144, 32'h1);
        chk("R12 partial mask", irq[1], 1);
        wr(12'h144, 32'h5);
        chk("R12 fully masked", irq[1], 0);
        wr(12'h140, 32'h1);
        rd(12'h140, v); chk("R11 w1c", v, 4);
        eng_evt[13] = 1'b1;
        wr(12'h140, 32'h1);
        eng_evt = '0;
        rd(12'h140, v); chk("R11 set wins", v, 5);
        wr(12'h140, 32'h1FFF);
        wr(12'h144, 32'h0);
        rd(12'h140, v); chk("R11 cleared", v, 0);
        chk("R12 irq idle", irq[1], 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule